// File: doc/BRIEF.md
# Slot Timing Power Sequencer

This block decides, one time slot at a time, which parts of a radio transceiver are powered and whether the frequency synthesizer loop is closed. It watches the enable line of the serial programming bus, an external VCO power input and an external receive-enable input. Four configuration bits, already decoded from the serial register, select the operating mode and the slot type. From these it drives the synthesizer enable, the loop-closed control, VCO power, the transmit preamplifier enable and receiver power. It also drives a receive-enable output and the direction control for that pin.

There are three operating modes. In the normal mode the outputs follow the external lines directly. In the reduced mode the serial enable line sequences the whole slot. A rising edge starts locking, the following falling edge opens the loop, and a second pulse ends the slot. The advanced mode is the same, except that the external VCO power line ends the slot. The analog settling times of the VCO and the preamplifier are modelled as cycle counts. A ready flag for each goes high once its count has expired.

Top module: `slot_power_seq`

## Requirements
- R1: The mode is taken from `cfg_new` and `cfg_spwr`. With `cfg_new`=0 the mode is normal, whatever the value of `cfg_spwr`. The value 10 gives the reduced mode and 11 gives the advanced mode.
- R2: In normal mode, `synth_en` and `loop_closed` equal `frame_en` AND `vco_pwr_in`. `vco_pwr` equals `vco_pwr_in`. `pa_en` equals NOT `cfg_rx_sel` AND `vco_pwr_in`. `rx_pwr` equals `rx_en_in` AND `vco_pwr_in`.
- R3: In reduced or advanced mode, a rising edge of `frame_en` while idle gives a one-cycle `pll_load` pulse and sets `synth_en` and `loop_closed`. In reduced mode it also turns on `vco_pwr`.
- R4: `pa_en` is high only when the slot is a transmit slot (`cfg_rx_sel`=0) and `vco_pwr` is high. `rx_pwr` is high only in a receive slot while `vco_pwr` is high.
- R5: The falling edge that ends the first pulse drops `synth_en` and `loop_closed`, unless `cfg_hold_loop`=1. With `cfg_rx_sel`=1 it turns on `rx_pwr`; otherwise the transmit state is kept.
- R6: In reduced mode, the VCO is powered from the first rising edge, without regard to `vco_pwr_in`. A second rising edge of `frame_en` powers everything down for one cycle, after which the block is idle. A falling edge while idle has no effect.
- R7: In advanced mode, `vco_pwr` follows `vco_pwr_in`. A falling edge of `vco_pwr_in` during a slot powers everything down. A second rising edge of `frame_en` has no effect.
- R8: In reduced and advanced modes, `rx_en_oe` is 1 and `rx_en_out` mirrors `rx_pwr`. In normal mode both are 0.
- R9: `vco_ready` rises exactly VCO-settle cycles after `vco_pwr` rises. `pa_ready` rises exactly PA-settle cycles after `pa_en` rises. Each flag drops in the same cycle that its power signal drops.
- R10: The slot type and the loop-hold bit are captured at the first rising edge. Changes to them later in the slot have no effect.
- R11: All outputs are registered with one cycle of latency, and all are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | Serial bus enable line, also used as the slot strobe |
| vco_pwr_in | input | 1 | External VCO power line |
| rx_en_in | input | 1 | External receive enable (normal mode) |
| cfg_new | input | 1 | Mode bit: 1 selects serial-sequenced operation |
| cfg_spwr | input | 1 | Mode bit: 1 selects the advanced mode |
| cfg_hold_loop | input | 1 | Keep the loop closed after the first pulse |
| cfg_rx_sel | input | 1 | Slot type: 1 receive, 0 transmit |
| pll_load | output | 1 | One-cycle pulse that loads the divider |
| synth_en | output | 1 | Synthesizer enable |
| loop_closed | output | 1 | Phase-locked loop closed |
| vco_pwr | output | 1 | VCO power |
| pa_en | output | 1 | Transmit preamplifier enable |
| rx_pwr | output | 1 | Receiver power |
| rx_en_out | output | 1 | Receive-enable pin value when driven |
| rx_en_oe | output | 1 | Receive-enable pin output enable |
| vco_ready | output | 1 | VCO settling time elapsed |
| pa_ready | output | 1 | Preamplifier settling time elapsed |

## Verification
The bench checks that the settle flags rise exactly on the programmed count and drop at once. A design that is one count off, or that lags by a register on the way down, gives a wrong flag in one of those cycles. The bench changes the slot type in the middle of a transmit slot. A design that reads the live bit instead of the captured one then turns on the receiver. The bench sends a second enable pulse in advanced mode and toggles the external VCO line in reduced mode. A design that swapped the power-down sources would end the slot early or keep it alive. In advanced mode the bench starts a slot with the external VCO line low. This catches a preamplifier that is not gated by VCO power.

// File: rtl/slot_seq_pkg.sv
// Package: shared types for the slot power sequencer.
// Assumes: nothing; holds only types and a pure decode function.
package slot_seq_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_REDUCED  = 2'd1,
        MODE_ADVANCED = 2'd2
    } slot_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOCKING   = 3'd1,
        ST_ACTIVE_TX = 3'd2,
        ST_ACTIVE_RX = 3'd3,
        ST_POWERDOWN = 3'd4
    } slot_state_e;

    typedef struct packed {
        logic synth;
        logic loop;
        logic vco;
        logic pa;
        logic rx;
        logic rx_out;
        logic rx_oe;
        logic load;
    } slot_ctrl_t;

    // Map the two mode bits onto an operating mode.
    function automatic slot_mode_e decode_mode(input logic new_bit, input logic spwr_bit);
        if (!new_bit)
            return MODE_NORMAL;
        else if (spwr_bit)
            return MODE_ADVANCED;
        else
            return MODE_REDUCED;
    endfunction

endpackage

// File: rtl/slot_edge_det.sv
// Module: slot_edge_det
// Registers each input line once and flags rising and falling edges
// combinationally against the stored value.
// Assumes: inputs are already synchronous to clk.
module slot_edge_det #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    logic [LINES-1:0] prev_q;

    // Store the previous level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= lvl;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Edge flags for one line.
        assign rise[i] = lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] & prev_q[i];
    end
endmodule

// File: rtl/slot_settle_timer.sv
// Module: slot_settle_timer
// Counts cycles while its power input is high and raises ready once
// LIMIT cycles have passed; ready drops in the same cycle power drops.
// Assumes: LIMIT >= 1.
module slot_settle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    output logic ready
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Count up while powered, saturate with done set, clear when unpowered.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (cnt_q == CW'(LIMIT - 1)) begin
            done_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Ready only while power is still present.
    assign ready = done_q & pwr;
endmodule

// File: rtl/slot_fsm.sv
// Module: slot_fsm
// Slot state machine: IDLE -> LOCKING -> ACTIVE_TX/RX -> POWERDOWN -> IDLE.
// Captures mode, slot type and loop hold at the first enable rise.
// Exposes next-state values so the output stage registers with them.
// Assumes: edge flags come from slot_edge_det on the same clock.
module slot_fsm
    import slot_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fe_rise,
    input  logic        fe_fall,
    input  logic        vi_fall,
    input  slot_mode_e  mode_live,
    input  logic        hold_live,
    input  logic        rxsel_live,
    output slot_state_e state_d,
    output slot_mode_e  mode_d,
    output logic        hold_d,
    output logic        rxsel_d,
    output logic        start_d
);
    slot_state_e state_q;
    slot_mode_e  mode_q;
    logic        hold_q;
    logic        rxsel_q;
    logic        end_evt;

    // The event that closes a slot depends on the captured mode.
    always_comb begin
        end_evt = 1'b0;
        if (mode_q == MODE_REDUCED)
            end_evt = fe_rise;
        else if (mode_q == MODE_ADVANCED)
            end_evt = vi_fall;
    end

    // Next-state and capture logic.
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        hold_d  = hold_q;
        rxsel_d = rxsel_q;
        start_d = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (fe_rise && mode_live != MODE_NORMAL) begin
                    state_d = ST_LOCKING;
                    mode_d  = mode_live;
                    hold_d  = hold_live;
                    rxsel_d = rxsel_live;
                    start_d = 1'b1;
                end
            end
            ST_LOCKING: begin
                if (mode_q == MODE_ADVANCED && vi_fall)
                    state_d = ST_POWERDOWN;
                else if (fe_fall)
                    state_d = rxsel_q ? ST_ACTIVE_RX : ST_ACTIVE_TX;
            end
            ST_ACTIVE_TX, ST_ACTIVE_RX: begin
                if (end_evt)
                    state_d = ST_POWERDOWN;
            end
            ST_POWERDOWN: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and captured-configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_NORMAL;
            hold_q  <= 1'b0;
            rxsel_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            hold_q  <= hold_d;
            rxsel_q <= rxsel_d;
        end
    end
endmodule

// File: rtl/slot_out_stage.sv
// Module: slot_out_stage
// Decodes next state plus live lines into control outputs and registers
// them, giving one cycle of latency from any input change.
// Assumes: in IDLE the live mode and slot bits apply; otherwise captured.
module slot_out_stage
    import slot_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  slot_state_e state_d,
    input  slot_mode_e  mode_cap,
    input  slot_mode_e  mode_live,
    input  logic        hold_cap,
    input  logic        rxsel_cap,
    input  logic        rxsel_live,
    input  logic        start_d,
    input  logic        fe,
    input  logic        vi,
    input  logic        ri,
    output slot_ctrl_t  ctrl_q
);
    slot_mode_e mode_eff;
    logic       in_slot;
    logic       vco_on;
    slot_ctrl_t ctrl_d;

    // Select which mode governs the outputs this cycle.
    assign mode_eff = (state_d == ST_IDLE) ? mode_live : mode_cap;
    assign in_slot  = (state_d == ST_LOCKING) || (state_d == ST_ACTIVE_TX) ||
                      (state_d == ST_ACTIVE_RX);

    // VCO power source: external line in advanced mode, slot state in reduced.
    always_comb begin
        if (state_d == ST_POWERDOWN)
            vco_on = 1'b0;
        else if (mode_eff == MODE_ADVANCED)
            vco_on = vi;
        else
            vco_on = in_slot;
    end

    // Output decode for the next cycle.
    always_comb begin
        ctrl_d = '0;
        if (mode_eff == MODE_NORMAL && state_d == ST_IDLE) begin
            ctrl_d.synth = fe & vi;
            ctrl_d.loop  = fe & vi;
            ctrl_d.vco   = vi;
            ctrl_d.pa    = ~rxsel_live & vi;
            ctrl_d.rx    = ri & vi;
        end else begin
            ctrl_d.vco    = vco_on;
            ctrl_d.synth  = (state_d == ST_LOCKING) ||
                            (hold_cap && (state_d == ST_ACTIVE_TX || state_d == ST_ACTIVE_RX));
            ctrl_d.loop   = ctrl_d.synth;
            ctrl_d.pa     = ((state_d == ST_LOCKING) || (state_d == ST_ACTIVE_TX)) &&
                            !rxsel_cap && vco_on;
            ctrl_d.rx     = (state_d == ST_ACTIVE_RX) && vco_on;
            ctrl_d.rx_oe  = (mode_eff != MODE_NORMAL);
            ctrl_d.rx_out = ctrl_d.rx && ctrl_d.rx_oe;
            ctrl_d.load   = start_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/slot_power_seq.sv
// Module: slot_power_seq (top)
// Sequences synthesizer, loop, VCO, preamplifier and receiver power per
// time slot in three modes; models VCO and PA settling with cycle counters.
// Assumes: all inputs synchronous to clk; settle times given in microseconds
// at CLK_MHZ.
module slot_power_seq
    import slot_seq_pkg::*;
#(
    parameter int CLK_MHZ       = 250,
    parameter int VCO_SETTLE_US = 50,
    parameter int PA_SETTLE_US  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_en,
    input  logic vco_pwr_in,
    input  logic rx_en_in,
    input  logic cfg_new,
    input  logic cfg_spwr,
    input  logic cfg_hold_loop,
    input  logic cfg_rx_sel,
    output logic pll_load,
    output logic synth_en,
    output logic loop_closed,
    output logic vco_pwr,
    output logic pa_en,
    output logic rx_pwr,
    output logic rx_en_out,
    output logic rx_en_oe,
    output logic vco_ready,
    output logic pa_ready
);
    localparam int VCO_CYC = CLK_MHZ * VCO_SETTLE_US;
    localparam int PA_CYC  = CLK_MHZ * PA_SETTLE_US;
    localparam int N_EDGE  = 2;

    logic [N_EDGE-1:0] rise;
    logic [N_EDGE-1:0] fall;
    slot_mode_e        mode_live;
    slot_state_e       state_d;
    slot_mode_e        mode_d;
    logic              hold_d;
    logic              rxsel_d;
    logic              start_d;
    slot_ctrl_t        ctrl_q;

    assign mode_live = decode_mode(cfg_new, cfg_spwr);

    slot_edge_det #(.LINES(N_EDGE)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({vco_pwr_in, frame_en}),
        .rise (rise),
        .fall (fall)
    );

    slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fe_rise   (rise[0]),
        .fe_fall   (fall[0]),
        .vi_fall   (fall[1]),
        .mode_live (mode_live),
        .hold_live (cfg_hold_loop),
        .rxsel_live(cfg_rx_sel),
        .state_d   (state_d),
        .mode_d    (mode_d),
        .hold_d    (hold_d),
        .rxsel_d   (rxsel_d),
        .start_d   (start_d)
    );

    slot_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .mode_cap  (mode_d),
        .mode_live (mode_live),
        .hold_cap  (hold_d),
        .rxsel_cap (rxsel_d),
        .rxsel_live(cfg_rx_sel),
        .start_d   (start_d),
        .fe        (frame_en),
        .vi        (vco_pwr_in),
        .ri        (rx_en_in),
        .ctrl_q    (ctrl_q)
    );

    slot_settle_timer #(.LIMIT(VCO_CYC)) u_vco_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .pwr  (ctrl_q.vco),
        .ready(vco_ready)
    );

    slot_settle_timer #(.LIMIT(PA_CYC)) u_pa_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .pwr  (ctrl_q.pa),
        .ready(pa_ready)
    );

    assign pll_load    = ctrl_q.load;
    assign synth_en    = ctrl_q.synth;
    assign loop_closed = ctrl_q.loop;
    assign vco_pwr     = ctrl_q.vco;
    assign pa_en       = ctrl_q.pa;
    assign rx_pwr      = ctrl_q.rx;
    assign rx_en_out   = ctrl_q.rx_out;
    assign rx_en_oe    = ctrl_q.rx_oe;
endmodule

// File: rtl/slot_power_seq_chk.sv
// Module: slot_power_seq_chk
// Temporal checks on the sequencer's ports; attached by bind below.
// Assumes: synchronous active-low reset.
module slot_power_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_load,
    input logic synth_en,
    input logic loop_closed,
    input logic vco_pwr,
    input logic pa_en,
    input logic rx_pwr,
    input logic rx_en_out,
    input logic rx_en_oe,
    input logic vco_ready,
    input logic pa_ready
);
    // R3: divider load lasts one cycle.
    p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_load |=> !pll_load);

    // R3: the load cycle has the loop closed and the synthesizer on.
    p_load_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_load |-> (synth_en && loop_closed));

    // R4: preamplifier never on without VCO power.
    p_pa_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pa_en |-> vco_pwr);

    // R4: receiver never on without VCO power.
    p_rx_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pwr |-> vco_pwr);

    // R8: pin driven high only when the direction control selects output.
    p_pin_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_out |-> rx_en_oe);

    // R9: ready flags require their power source.
    p_vco_ready_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vco_ready |-> vco_pwr);

    p_pa_ready_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pa_ready |-> pa_en);

    // R9: VCO ready never rises in the same cycle power appears.
    p_vco_ready_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_ready) |-> $past(vco_pwr));
endmodule

bind slot_power_seq slot_power_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_load   (pll_load),
    .synth_en   (synth_en),
    .loop_closed(loop_closed),
    .vco_pwr    (vco_pwr),
    .pa_en      (pa_en),
    .rx_pwr     (rx_pwr),
    .rx_en_out  (rx_en_out),
    .rx_en_oe   (rx_en_oe),
    .vco_ready  (vco_ready),
    .pa_ready   (pa_ready)
);

// File: tb/slot_power_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: drive() applies inputs at a falling edge and queues the
// expected output word; the monitor compares one cycle later, 1 ns after the
// rising edge. Word: {vco_ready, pa_ready, synth, loop, vco, pa, rx, rx_out,
// rx_oe, load}.
module slot_power_seq_tb_top;
    localparam int VCO_N = 6;
    localparam int PA_N  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_en = 0, vco_pwr_in = 0, rx_en_in = 0;
    logic cfg_new = 0, cfg_spwr = 0, cfg_hold_loop = 0, cfg_rx_sel = 0;
    logic pll_load, synth_en, loop_closed, vco_pwr, pa_en, rx_pwr;
    logic rx_en_out, rx_en_oe, vco_ready, pa_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [9:0] exp_q[$];
    logic [9:0] mask_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    slot_power_seq #(.CLK_MHZ(1), .VCO_SETTLE_US(VCO_N), .PA_SETTLE_US(PA_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .vco_pwr_in(vco_pwr_in),
        .rx_en_in(rx_en_in), .cfg_new(cfg_new), .cfg_spwr(cfg_spwr),
        .cfg_hold_loop(cfg_hold_loop), .cfg_rx_sel(cfg_rx_sel),
        .pll_load(pll_load), .synth_en(synth_en), .loop_closed(loop_closed),
        .vco_pwr(vco_pwr), .pa_en(pa_en), .rx_pwr(rx_pwr), .rx_en_out(rx_en_out),
        .rx_en_oe(rx_en_oe), .vco_ready(vco_ready), .pa_ready(pa_ready)
    );

    // Drive one cycle of inputs and queue the expected result.
    task automatic drive(input logic fe, input logic vi, input logic ri,
                         input logic nw, input logic sp, input logic hd, input logic tx,
                         input logic [9:0] exp, input logic [9:0] mask, input string tag);
        @(negedge clk);
        frame_en = fe; vco_pwr_in = vi; rx_en_in = ri;
        cfg_new = nw; cfg_spwr = sp; cfg_hold_loop = hd; cfg_rx_sel = tx;
        exp_q.push_back(exp);
        mask_q.push_back(mask);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare against the oldest expected word.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [9:0] e, m, a;
            string t;
            e = exp_q.pop_front();
            m = mask_q.pop_front();
            t = tag_q.pop_front();
            a = {vco_ready, pa_ready, synth_en, loop_closed, vco_pwr, pa_en,
                 rx_pwr, rx_en_out, rx_en_oe, pll_load};
            checks++;
            if ((a & m) !== (e & m)) begin
                fails++;
                $display("FAIL %s: actual %b expected %b (mask %b)", t, a, e, m);
            end
        end
    end

    localparam logic [9:0] M8  = 10'h0FF;
    localparam logic [9:0] ALL = 10'h3FF;

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        exp_q.push_back(10'h000); mask_q.push_back(ALL); tag_q.push_back("R11 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R9: settle flags in normal mode
        drive(0,0,0, 0,0,0,0, 10'h000, ALL, "R9 idle");
        for (int k = 0; k < 8; k++)
            drive(0,1,0, 0,0,0,0, {(k >= VCO_N), (k >= PA_N), 8'b0011_0000}, ALL, "R9 settle");
        drive(0,0,0, 0,0,0,0, 10'h000, ALL, "R9 drop");

        // R2 / R1: normal mode follows the lines, independent of cfg_spwr
        drive(0,1,0, 0,0,0,0, {2'b00, 8'b0011_0000}, M8, "R2 vco only");
        drive(1,1,0, 0,0,0,0, {2'b00, 8'b1111_0000}, M8, "R2 tx");
        drive(1,1,1, 0,0,0,1, {2'b00, 8'b1110_1000}, M8, "R2 rx");
        drive(1,0,1, 0,1,0,1, {2'b00, 8'b0000_0000}, M8, "R1 spwr ignored, vco off");
        drive(1,1,1, 0,1,0,1, {2'b00, 8'b1110_1000}, M8, "R1 normal with spwr");

        // Reduced mode, transmit, no hold: R3 R5 R6 R10 R8
        drive(0,0,0, 1,0,0,0, {2'b00, 8'b0000_0010}, M8, "R8 reduced idle");
        drive(1,0,0, 1,0,0,0, {2'b00, 8'b1111_0011}, M8, "R3 first rise");
        drive(1,0,0, 1,0,0,0, {2'b00, 8'b1111_0010}, M8, "R3 locking");
        drive(0,0,0, 1,0,0,0, {2'b00, 8'b0011_0010}, M8, "R5 loop opens tx");
        drive(0,0,1, 1,0,1,1, {2'b00, 8'b0011_0010}, M8, "R10 slot bits ignored");
        drive(1,0,0, 1,0,0,0, {2'b00, 8'b0000_0010}, M8, "R6 second pulse powerdown");
        drive(1,0,0, 1,0,0,0, {2'b00, 8'b0000_0010}, M8, "R6 back to idle");
        drive(0,0,0, 1,0,0,0, {2'b00, 8'b0000_0010}, M8, "R6 idle fall ignored");

        // Reduced mode, receive, hold loop
        drive(1,0,0, 1,0,1,1, {2'b00, 8'b1110_0011}, M8, "R4 rx slot no pa");
        drive(0,0,0, 1,0,1,1, {2'b00, 8'b1110_1110}, M8, "R5 hold loop rx on");
        drive(0,1,0, 1,0,1,1, {2'b00, 8'b1110_1110}, M8, "R6 ext vco ignored");
        drive(0,0,0, 1,0,1,1, {2'b00, 8'b1110_1110}, M8, "R6 ext vco fall ignored");
        drive(1,0,0, 1,0,1,1, {2'b00, 8'b0000_0010}, M8, "R6 powerdown rx");
        drive(1,0,0, 1,0,1,1, {2'b00, 8'b0000_0010}, M8, "R6 idle");
        drive(0,0,0, 1,0,0,0, {2'b00, 8'b0000_0010}, M8, "R6 idle");

        // Advanced mode, receive, no hold: R7 R8
        drive(0,1,0, 1,1,0,1, {2'b00, 8'b0010_0010}, M8, "R7 idle vco follows");
        drive(1,1,0, 1,1,0,1, {2'b00, 8'b1110_0011}, M8, "R3 advanced rise");
        drive(0,1,0, 1,1,0,1, {2'b00, 8'b0010_1110}, M8, "R8 rx mirrored");
        drive(1,1,0, 1,1,0,1, {2'b00, 8'b0010_1110}, M8, "R7 second rise ignored");
        drive(0,1,0, 1,1,0,1, {2'b00, 8'b0010_1110}, M8, "R7 fall ignored");
        drive(0,0,0, 1,1,0,1, {2'b00, 8'b0000_0010}, M8, "R7 vco fall powerdown");
        drive(0,0,0, 1,1,0,1, {2'b00, 8'b0000_0010}, M8, "R7 idle");

        // Advanced mode, vco fall during locking
        drive(0,1,0, 1,1,0,0, {2'b00, 8'b0010_0010}, M8, "R7 idle");
        drive(1,1,0, 1,1,0,0, {2'b00, 8'b1111_0011}, M8, "R3 tx rise");
        drive(1,0,0, 1,1,0,0, {2'b00, 8'b0000_0010}, M8, "R7 powerdown in locking");
        drive(1,0,0, 1,1,0,0, {2'b00, 8'b0000_0010}, M8, "R7 idle");

        // Advanced mode, slot started with external VCO low: R4
        drive(0,0,0, 1,1,0,0, {2'b00, 8'b0000_0010}, M8, "R4 idle");
        drive(1,0,0, 1,1,0,0, {2'b00, 8'b1100_0011}, M8, "R4 pa gated by vco");
        drive(1,1,0, 1,1,0,0, {2'b00, 8'b1111_0010}, M8, "R4 pa with vco");
        drive(0,1,0, 1,1,0,0, {2'b00, 8'b0011_0010}, M8, "R5 tx loop open");
        drive(0,0,0, 1,1,0,0, {2'b00, 8'b0000_0010}, M8, "R7 end of tx slot");
        drive(0,0,0, 1,1,0,0, {2'b00, 8'b0000_0010}, M8, "R7 idle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule